// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block turns a one-bit serial stream into 4-bit parallel words. Every rising edge of the serial clock samples the stream. A 2-bit divide counter, also running on the serial clock, decides when a complete word is moved into the output register. The same counter produces a registered word clock at one quarter of the serial rate. Each word rises onto the output together with a rising edge of the word clock. The earliest bit of a word lands on the most significant output bit.

Framing logic downstream can move the word boundary by one bit position. It does this by raising the alignment request input for at least two serial clock cycles. The block answers by holding its divide counter for one extra serial cycle. That one word period therefore lasts five serial bits, the first bit of that period is thrown away, and every later word is shifted by one bit. A request shorter than two cycles is ignored. A request held high for a long time causes only one slip until it falls and rises again.

Top module: `deser_slip`

## Requirements
- R1: Every rising edge of `ser_clk` samples `ser_bit`, with no gaps. Each word placed on `word_out` is made of the four bits sampled at the four most recent edges, the last of those edges being the load edge.
- R2: `word_clk` is a registered output. Outside a slip it rises once every 4 serial edges.
- R3: `word_out` changes only on the serial edge at which `word_clk` rises. That edge is the one at which the divide counter leaves its terminal count of 3.
- R4: Bit order is most-significant-first. The earliest of the four bits goes to `word_out[3]` and the latest goes to `word_out[0]`. For example, the serial sequence 1,0,0,0 gives 4'b1000.
- R5: `align_req` is qualified only when it is sampled high at two consecutive serial edges. A pulse sampled high at a single edge changes neither the word boundary nor the spacing of `word_clk`.
- R6: A qualified request stretches exactly one word period to 5 serial edges. The bit sampled first in that period is discarded. The following words continue from the bits after it, so the boundary moves by one bit.
- R7: Each rising edge of `align_req` causes at most one slip, however long the input stays high. Two separate qualified pulses cause two slips.
- R8: Let E be the first serial edge that samples `align_req` high. The stretched word is loaded no earlier than 6 and no later than 9 serial edges after E. This is within two word clock periods of the request.
- R9: While `rst_n` is low, `word_clk` and `word_out` are 0. After release, the first word is loaded at the fourth serial edge and holds the first four bits sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial bit clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bit | input | 1 | Serial data, one bit per serial clock |
| align_req | input | 1 | Boundary-slip request; must be high for two or more serial clocks |
| word_clk | output | 1 | Registered parallel clock at one quarter of the serial rate |
| word_out | output | 4 | Parallel word, earliest bit in the top position |

## Verification
The bench sends a pseudo-random bit stream through a table of request scenarios. It compares every loaded word with the bits it remembers sending. A design with reversed bit order or a gap in sampling fails on the first word. One-cycle glitches must leave every word spacing at four. A design that qualifies too early would show a five-edge period there. Long and repeated requests must give exactly one stretched period per rising edge. A design without the one-shot qualifier would slip again and again. The moment of the stretched load is checked against its window, which catches a slip that comes too late or is applied at the wrong counter phase.

// File: rtl/deser_slip_pkg.sv
package deser_slip_pkg;

   // true when v is a power of two no smaller than 2
   function automatic bit width_ok(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // counter width able to hold 0..v
   function automatic int run_w(input int v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/deser_shift.sv
module deser_shift #(
   parameter int WORD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_in,
   output logic [WORD_W-1:0] shift_next
);
   logic [WORD_W-1:0] shift_q;

   // earliest bit drifts toward the top as later bits enter at bit 0
   assign shift_next[0] = bit_in;
   for (genvar g = 1; g < WORD_W; g++) begin : g_stage
      assign shift_next[g] = shift_q[g-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= shift_next;
   end
endmodule

// File: rtl/deser_sync_qual.sv
module deser_sync_qual
   import deser_slip_pkg::*;
#(
   parameter int MIN_HIGH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   output logic req_pulse
);
   localparam int RW = run_w(MIN_HIGH);
   localparam logic [RW-1:0] LAST = RW'(MIN_HIGH - 1);
   localparam logic [RW-1:0] SAT  = RW'(MIN_HIGH);

   logic [RW-1:0] run_q;

   // run length saturates, so one high stretch yields one pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= '0;
         req_pulse <= 1'b0;
      end else begin
         req_pulse <= req_in && (run_q == LAST);
         if (!req_in)          run_q <= '0;
         else if (run_q < SAT) run_q <= run_q + 1'b1;
      end
   end
endmodule

// File: rtl/deser_divider.sv
module deser_divider #(
   parameter int WORD_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      slip,
   output logic                      load,
   output logic                      hold,
   output logic                      div_clk,
   output logic [$clog2(WORD_W)-1:0] count
);
   localparam int CW = $clog2(WORD_W);
   localparam logic [CW-1:0] TERM = CW'(WORD_W - 1);
   localparam logic [CW-1:0] HALF = CW'(WORD_W / 2);

   logic [CW-1:0] cnt_q, cnt_d;
   logic          pend_q;
   logic          clk_q;

   // the stall is applied just after a load, so the new period's first bit is lost
   assign hold  = (pend_q || slip) && (cnt_q == '0);
   assign load  = (cnt_q == TERM);
   assign cnt_d = hold ? cnt_q : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         clk_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         pend_q <= (pend_q || slip) && !hold;
         if (load)               clk_q <= 1'b1;
         else if (cnt_d == HALF) clk_q <= 1'b0;
      end
   end

   assign div_clk = clk_q;
   assign count   = cnt_q;
endmodule

// File: rtl/deser_slip.sv
module deser_slip
   import deser_slip_pkg::*;
#(
   parameter int WORD_W   = 4,
   parameter int MIN_HIGH = 2
) (
   input  logic              ser_clk,
   input  logic              rst_n,
   input  logic              ser_bit,
   input  logic              align_req,
   output logic              word_clk,
   output logic [WORD_W-1:0] word_out
);
   localparam int CW = $clog2(WORD_W);

   if (!width_ok(WORD_W)) begin : g_bad_width
      $error("deser_slip: WORD_W must be a power of two >= 2");
   end
   if (MIN_HIGH < 1) begin : g_bad_min
      $error("deser_slip: MIN_HIGH must be at least 1");
   end

   logic [WORD_W-1:0] shift_w;
   logic              req_w;
   logic              load_w;
   logic              hold_w;
   logic [CW-1:0]     cnt_w;
   logic [WORD_W-1:0] word_q;

   deser_shift #(.WORD_W(WORD_W)) shift_i (
      .clk(ser_clk), .rst_n(rst_n), .bit_in(ser_bit), .shift_next(shift_w));

   deser_sync_qual #(.MIN_HIGH(MIN_HIGH)) qual_i (
      .clk(ser_clk), .rst_n(rst_n), .req_in(align_req), .req_pulse(req_w));

   deser_divider #(.WORD_W(WORD_W)) div_i (
      .clk(ser_clk), .rst_n(rst_n), .slip(req_w), .load(load_w),
      .hold(hold_w), .div_clk(word_clk), .count(cnt_w));

   always_ff @(posedge ser_clk or negedge rst_n) begin
      if (!rst_n)      word_q <= '0;
      else if (load_w) word_q <= shift_w;
   end

   assign word_out = word_q;
endmodule

// File: rtl/deser_slip_chk.sv
module deser_slip_chk #(
   parameter int WORD_W = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ser_bit,
   input logic                      align_req,
   input logic                      word_clk,
   input logic [WORD_W-1:0]         word_out,
   input logic [$clog2(WORD_W)-1:0] cnt,
   input logic                      req,
   input logic                      hold
);
   localparam logic [$clog2(WORD_W)-1:0] TERM = $clog2(WORD_W)'(WORD_W - 1);

   p_word_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(word_clk) |-> $stable(word_out));

   p_load_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TERM) |=> $rose(word_clk));

   p_latest_bit_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_clk) |-> (word_out[0] == $past(ser_bit)));

   p_req_two_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> ($past(align_req) && $past(align_req, 2)));

   p_single_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !hold);

   p_clk_high_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_clk) |=> word_clk);
endmodule

bind deser_slip deser_slip_chk #(.WORD_W(WORD_W)) chk_i (
   .clk(ser_clk), .rst_n(rst_n), .ser_bit(ser_bit), .align_req(align_req),
   .word_clk(word_clk), .word_out(word_out), .cnt(cnt_w), .req(req_w),
   .hold(hold_w));

// File: tb/deser_slip_tb_top.sv
module deser_slip_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_bit = 1'b0;
   logic       align_req = 1'b0;
   logic       word_clk;
   logic [3:0] word_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] hist;
   int edge_n, last_load, first_load, slip_cnt, slip_end, bad_iv;
   logic clk_prev;
   logic [7:0] lfsr = 8'hA5;

   // scenarios: {offset, length, expected slips}
   localparam int SCN[6][3] = '{'{5,1,0}, '{6,2,1}, '{3,3,1},
                                '{7,12,1}, '{2,1,0}, '{9,2,1}};

   always #5 clk = ~clk;

   deser_slip dut_i (.ser_clk(clk), .rst_n(rst_n), .ser_bit(ser_bit),
      .align_req(align_req), .word_clk(word_clk), .word_out(word_out));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one bit, take one edge, observe at the falling edge
   task automatic tick(input logic b, input logic s);
      ser_bit = b;
      align_req = s;
      @(posedge clk);
      edge_n++;
      hist[edge_n % 16] = b;
      @(negedge clk);
      if (word_clk && !clk_prev) begin
         logic [3:0] exp_w;
         exp_w = {hist[(edge_n-3) % 16], hist[(edge_n-2) % 16],
                  hist[(edge_n-1) % 16], hist[edge_n % 16]};
         check(word_out == exp_w, "R1 word contents", word_out, exp_w);
         if (last_load < 0) first_load = edge_n;
         else if (edge_n - last_load == 5) begin
            slip_cnt++;
            slip_end = edge_n;
         end else if (edge_n - last_load != 4) bad_iv++;
         last_load = edge_n;
      end
      clk_prev = word_clk;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ser_bit = 1'b0;
      align_req = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(word_clk == 1'b0, "R9 reset word_clk", word_clk, 0);
      check(word_out == 4'h0, "R9 reset word_out", word_out, 0);
      rst_n = 1'b1;
      edge_n = 0;
      last_load = -1;
      first_load = -1;
      clk_prev = 1'b0;
   endtask

   function automatic logic next_bit();
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      return lfsr[0];
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // reset, first load and bit order
      do_reset();
      tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
      check(first_load == 4, "R9 first load edge", first_load, 4);
      check(word_out == 4'b1000, "R4 earliest bit on top", word_out, 4'b1000);
      tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b1, 1'b1 ^ 1'b1); tick(1'b1, 1'b0);
      check(word_out == 4'b0011, "R4 latest bits low", word_out, 4'b0011);

      // scenario table
      for (int k = 0; k < 6; k++) begin
         int e_first;
         do_reset();
         slip_cnt = 0;
         bad_iv = 0;
         slip_end = -1;
         e_first = -1;
         repeat (12) tick(next_bit(), 1'b0);
         for (int c = 0; c < 40; c++) begin
            logic s;
            s = (c >= SCN[k][0]) && (c < SCN[k][0] + SCN[k][1]);
            if (c == SCN[k][0]) e_first = edge_n + 1;
            tick(next_bit(), s);
         end
         check(slip_cnt == SCN[k][2],
               (SCN[k][2] == 0) ? "R5 glitch ignored" : "R7 one slip per rise",
               slip_cnt, SCN[k][2]);
         check(bad_iv == 0, "R2 word spacing", bad_iv, 0);
         if (SCN[k][2] == 1)
            check(slip_end >= e_first + 6 && slip_end <= e_first + 9,
                  "R8 slip latency", slip_end - e_first, 9);
      end

      // two separate qualified pulses: two slips, words stay consistent (R6)
      do_reset();
      slip_cnt = 0;
      bad_iv = 0;
      repeat (8) tick(next_bit(), 1'b0);
      repeat (2) tick(next_bit(), 1'b1);
      repeat (14) tick(next_bit(), 1'b0);
      repeat (3) tick(next_bit(), 1'b1);
      repeat (16) tick(next_bit(), 1'b0);
      check(slip_cnt == 2, "R7 two pulses two slips", slip_cnt, 2);
      check(bad_iv == 0, "R6 stretched period is five", bad_iv, 0);

      // word changes only at word_clk rise (R3)
      begin
         logic [3:0] held;
         int changes;
         changes = 0;
         held = word_out;
         for (int c = 0; c < 20; c++) begin
            tick(next_bit(), 1'b0);
            if (word_out != held && !(word_clk && edge_n == last_load)) changes++;
            held = word_out;
         end
         check(changes == 0, "R3 output stable between loads", changes, 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule